// File: doc/BRIEF.md
# Control Symbol CRC-5 Unit

This block protects the 24-bit link-layer control symbols of a serial packet link with a 5-bit CRC. A single shared CRC datapath serves both directions. In generate mode the transmit path presents a symbol whose low five bits are don't-care. The block returns the same symbol with those five bits replaced by the CRC of the upper 19 bits, ready to be merged between packets.

In check mode the receive path presents a symbol as received. The block recomputes the CRC over the upper 19 bits and compares it with the carried field. On a mismatch it raises an error flag, which the transmit-acknowledge control logic consumes. The CRC is computed combinationally. By default a register stage follows, and a valid strobe qualifies every result.

Top module: `ctl_sym_crc5`

## Requirements
- R1: The CRC uses generator polynomial x^5+x^4+x^2+1 (feedback mask 5'b10101) with the register preset to 5'b11111 and no final inversion. It is shifted over symbol bits 23 down to 5, MSB first. In generate mode (mode_i = 0) sym_o equals {sym_i[23:5], crc}.
- R2: In generate mode, the incoming bits sym_i[4:0] have no effect on any output.
- R3: In check mode (mode_i = 1), sym_o equals sym_i unchanged. err_o is 1 exactly when sym_i[4:0] differs from the CRC of sym_i[23:5].
- R4: valid_o is 1 in the cycle after each cycle with valid_i = 1 and 0 otherwise. Symbols may be accepted back to back on every clock, including mode changes between consecutive symbols.
- R5: err_o is 0 whenever valid_o is 0, and 0 for every generate-mode result.
- R6: While valid_i is 0, sym_o keeps its last value.
- R7: While rst_ni is low and after its release until the first accepted symbol, valid_o, err_o and sym_o are all 0.
- R8: Flipping any single bit of a symbol whose CRC field is correct makes the check-mode result report err_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input symbol valid |
| mode_i | input | 1 | 0 = generate CRC, 1 = check CRC |
| sym_i | input | 24 | Input control symbol, CRC field in bits 4:0 |
| valid_o | output | 1 | Result valid |
| sym_o | output | 24 | Symbol with CRC filled (generate) or passed through (check) |
| err_o | output | 1 | CRC mismatch flag, check mode only |

## Verification
Every result is due exactly one clock after the cycle in which valid_i was high: the single output register is the only storage between the input and the output. The bench drives inputs on the falling edge. Its behavioural model updates its expected valid, symbol and error on the rising edge, using a bitwise serial LFSR. The outputs are compared against that model on every following falling edge, so each comparison lands one cycle after its stimulus. Idle gaps check that the strobe drops, the error stays low and the symbol holds. Single-bit flips over all 24 positions check error detection.

// File: rtl/crc5_pkg.sv
package crc5_pkg;
  localparam int unsigned SYM_W  = 24;
  localparam int unsigned CRC_W  = 5;
  localparam logic [CRC_W-1:0] POLY = 5'b10101;  // x^5 term implicit
  localparam logic [CRC_W-1:0] INIT = 5'b11111;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } crc_mode_e;

  // one serial shift of a Galois LFSR, data MSB first
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] crc,
                                                 input logic [CRC_W-1:0] poly,
                                                 input logic d);
    logic fb;
    fb = crc[CRC_W-1] ^ d;
    return {crc[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/crc5_tree.sv
module crc5_tree #(
  parameter int unsigned DATA_W = 19,
  parameter int unsigned CRC_W  = 5,
  parameter logic [CRC_W-1:0] POLY = 5'b10101,
  parameter logic [CRC_W-1:0] INIT = 5'b11111
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] chain [DATA_W+1];

  assign chain[0] = INIT;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign chain[g+1] = crc5_pkg::crc_step(chain[g], POLY, data_i[DATA_W-1-g]);
  end

  assign crc_o = chain[DATA_W];
endmodule

// File: rtl/crc5_out_stage.sv
module crc5_out_stage #(
  parameter int unsigned SYM_W   = 24,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             err_i,
  output logic             valid_o,
  output logic [SYM_W-1:0] sym_o,
  output logic             err_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        sym_o   <= '0;
        err_o   <= 1'b0;
      end else begin
        valid_o <= valid_i;
        err_o   <= valid_i & err_i;
        if (valid_i) sym_o <= sym_i;
      end
    end

    p_valid_lat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    p_valid_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    p_err_qual_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> !err_o);
    p_sym_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(sym_o));
  end else begin : g_comb
    assign valid_o = valid_i;
    assign sym_o   = sym_i;
    assign err_o   = valid_i & err_i;

    always_comb begin
      if (!valid_o) p_err_qual_comb_r5: assert (!err_o);
    end
  end
endmodule

// File: rtl/ctl_sym_crc5.sv
module ctl_sym_crc5 #(
  parameter int unsigned SYM_W   = crc5_pkg::SYM_W,
  parameter int unsigned CRC_W   = crc5_pkg::CRC_W,
  parameter logic [CRC_W-1:0] POLY = crc5_pkg::POLY,
  parameter logic [CRC_W-1:0] INIT = crc5_pkg::INIT,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             mode_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             valid_o,
  output logic [SYM_W-1:0] sym_o,
  output logic             err_o
);
  import crc5_pkg::*;

  localparam int unsigned DATA_W = SYM_W - CRC_W;

  logic [CRC_W-1:0] crc_calc;
  logic [SYM_W-1:0] sym_nxt;
  logic             err_nxt;
  crc_mode_e        mode;

  assign mode = crc_mode_e'(mode_i);

  crc5_tree #(
    .DATA_W (DATA_W),
    .CRC_W  (CRC_W),
    .POLY   (POLY),
    .INIT   (INIT)
  ) u_tree (
    .data_i (sym_i[SYM_W-1:CRC_W]),
    .crc_o  (crc_calc)
  );

  always_comb begin
    if (mode == MODE_CHK) begin
      sym_nxt = sym_i;
      err_nxt = (sym_i[CRC_W-1:0] != crc_calc);
    end else begin
      sym_nxt = {sym_i[SYM_W-1:CRC_W], crc_calc};  // incoming CRC field dropped
      err_nxt = 1'b0;
    end
  end

  crc5_out_stage #(
    .SYM_W   (SYM_W),
    .REG_OUT (REG_OUT)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sym_i   (sym_nxt),
    .err_i   (err_nxt),
    .valid_o (valid_o),
    .sym_o   (sym_o),
    .err_o   (err_o)
  );

  if (REG_OUT) begin : g_chk
    p_gen_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !mode_i) |=> sym_o[SYM_W-1:CRC_W] == $past(sym_i[SYM_W-1:CRC_W]));
    p_chk_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && mode_i) |=> sym_o == $past(sym_i));
    p_gen_noerr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !mode_i) |=> !err_o);
  end
endmodule

// File: tb/ctl_sym_crc5_bench.sv
module ctl_sym_crc5_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [23:0] sym_i = '0;
  logic        valid_o;
  logic [23:0] sym_o;
  logic        err_o;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_tag = "R7";

  logic        exp_valid = 1'b0;
  logic [23:0] exp_sym = '0;
  logic        exp_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_sym_crc5 u_ctl_sym_crc5 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .valid_i (valid_i),
    .mode_i  (mode_i),
    .sym_i   (sym_i),
    .valid_o (valid_o),
    .sym_o   (sym_o),
    .err_o   (err_o)
  );

  // bitwise serial LFSR reference
  function automatic logic [4:0] ref_crc(input logic [23:0] s);
    logic [4:0] r;
    logic       t;
    r = 5'b11111;
    for (int i = 23; i >= 5; i--) begin
      t = r[4] ^ s[i];
      r = r << 1;
      if (t) r = r ^ 5'b10101;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_sym   <= '0;
      exp_err   <= 1'b0;
    end else begin
      exp_valid <= valid_i;
      if (valid_i) begin
        if (mode_i) begin
          exp_sym <= sym_i;
          exp_err <= (sym_i[4:0] != ref_crc(sym_i));
        end else begin
          exp_sym <= {sym_i[23:5], ref_crc(sym_i)};
          exp_err <= 1'b0;
        end
      end else begin
        exp_err <= 1'b0;
      end
    end
  end

  task automatic chk1(input string what, input logic [23:0] act, input logic [23:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk1("valid_o (R4)", {23'd0, valid_o}, {23'd0, exp_valid});
      chk1("sym_o", sym_o, exp_sym);
      chk1("err_o (R5)", {23'd0, err_o}, {23'd0, exp_err});
    end
  end

  task automatic send(input logic m, input logic [23:0] s);
    @(negedge clk);
    valid_i = 1'b1;
    mode_i  = m;
    sym_i   = s;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      mode_i  = $urandom_range(1);
      sym_i   = $urandom;
    end
  endtask

  initial begin
    logic [23:0] s;
    logic [23:0] good;
    cur_tag = "R7";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    cur_tag = "R1";
    send(1'b0, 24'h000000);
    send(1'b0, 24'hFFFFE0);
    for (int i = 0; i < 150; i++) send(1'b0, {$urandom} & 24'hFFFFE0);

    cur_tag = "R2";
    for (int i = 0; i < 150; i++) send(1'b0, $urandom);
    s = $urandom;
    for (int i = 0; i < 32; i++) send(1'b0, {s[23:5], i[4:0]});

    cur_tag = "R3";
    for (int i = 0; i < 150; i++) begin
      s = $urandom;
      send(1'b1, {s[23:5], ref_crc(s)});
      send(1'b1, s);
    end

    cur_tag = "R8";
    for (int k = 0; k < 8; k++) begin
      s = $urandom;
      good = {s[23:5], ref_crc(s)};
      send(1'b1, good);
      for (int b = 0; b < 24; b++) send(1'b1, good ^ (24'd1 << b));
    end

    cur_tag = "R6";
    for (int i = 0; i < 60; i++) begin
      s = $urandom;
      send(s[0], s[1] ? {s[23:5], ref_crc(s)} : s);
      idle(1 + (i % 3));
    end

    cur_tag = "R4";
    for (int i = 0; i < 300; i++) begin
      s = $urandom;
      if ($urandom_range(3) == 0) idle(1);
      else send($urandom_range(1), s[2] ? {s[23:5], ref_crc(s)} : s);
    end
    idle(2);

    cur_tag = "R7";
    @(negedge clk);
    rst_n = 1'b0;
    valid_i = 1'b1;
    sym_i = 24'hABCDEF;
    idle(2);
    rst_n = 1'b1;
    idle(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule